// File: doc/BRIEF.md
# Sequential Integer Power Unit

This unit raises an integer base to an integer exponent over several clock cycles. It follows the power-operator rules of hardware description languages. The base and the result share one parameterised width, and the base may be read as signed or unsigned. The exponent has its own width and its own signedness control, and it never changes how the result is interpreted. All arithmetic wraps modulo two to the power of the result width.

For a positive exponent the unit loads a running base and an accumulator of 1. It then walks the exponent from its low bit upward. On each set bit it multiplies the accumulator by the running base, and after each bit it squares the running base. A negative base is first replaced by its magnitude, and the sign is put back in a final fix-up cycle when the exponent is odd.

A negative exponent does not use the loop. Its result is settled in the setup cycle, and a zero base raised to a negative power raises a result-unknown flag. The caller pulses `start` while the unit is idle and waits for the one-cycle `done` pulse. The result then stays unchanged until the next accepted start.

Top module: `int_pow_seq`

## Requirements
- R1: An exponent of zero gives a result of 1 for every base, including a base of zero.
- R2: For a positive exponent the result equals base to the power of exponent reduced modulo 2^WIDTH, and a zero base gives 0.
- R3: When `base_signed` is 1 and the base MSB is set, the base is negative. The result is the power of its magnitude, negated when the exponent is odd, and read in two's complement.
- R4: A negative exponent (`exp_signed`=1 and exponent MSB set) gives 0 when the base is above 1 or below -1, and gives 1 when the base is 1. An unsigned all-ones base counts as above 1.
- R5: A negative exponent with a signed base of -1 gives 1 for an even exponent and all ones (-1) for an odd exponent.
- R6: A zero base with a negative exponent drives `result_unknown` high with a placeholder result of 0. For every other operand pair `result_unknown` is low.
- R7: An unsigned base of 2 with an unsigned exponent gives 1 shifted left by the exponent, truncated to WIDTH. An exponent of WIDTH or more therefore gives 0.
- R8: A start taken while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, `busy` is low at that time, and it comes no later than EXP_W+2 clock edges after the edge that accepts the start.
- R9: A `start` asserted while `busy` is high is ignored. `result` changes only in the cycle in which `done` rises.
- R10: A synchronous active-high reset clears `busy`, `done`, `result` and `result_unknown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| base | input | WIDTH | Base operand |
| base_signed | input | 1 | Read base (and result) as two's complement |
| expo | input | EXP_W | Exponent operand |
| exp_signed | input | 1 | Read exponent as two's complement |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Power result, held until the next accepted start |
| result_unknown | output | 1 | Result is undefined (zero to a negative power) |

## Verification
The bench builds the unit with WIDTH=8 and EXP_W=4. These values make it possible to cover every signed pair of base and exponent in -4..3 and every unsigned pair in 0..7, and to compare each result with a plain repeated-multiplication model. The narrow exponent also lets an unsigned base of 2 be raised to powers past the result width, where the result must wrap to zero. The full four-bit loop, which sets the worst-case latency bound, stays short enough to time on every run.

// File: rtl/int_pow_seq.sv
module int_pow_seq #(
  parameter int WIDTH = 16,
  parameter int EXP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] base,
  input  logic             base_signed,
  input  logic [EXP_W-1:0] expo,
  input  logic             exp_signed,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             result_unknown
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  typedef enum logic [1:0] {IDLE, LOOP, FIX} st_t;
  st_t state;

  logic [WIDTH-1:0] acc, sq;
  logic [EXP_W-1:0] e;
  logic             neg, unk;

  wire              e_neg  = exp_signed & expo[EXP_W-1];
  wire              b_neg  = base_signed & base[WIDTH-1];
  wire  [WIDTH-1:0] b_mag  = b_neg ? -base : base;
  wire              b_mone = b_neg && (b_mag == ONE);
  wire              take   = start && (state == IDLE);

  assign busy = (state != IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= IDLE;
      acc            <= ZERO;
      sq             <= ZERO;
      e              <= '0;
      neg            <= 1'b0;
      unk            <= 1'b0;
      done           <= 1'b0;
      result         <= ZERO;
      result_unknown <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (take) begin
          if (e_neg) begin
            acc   <= (base == ONE || b_mone) ? ONE : ZERO;
            neg   <= b_mone & expo[0];
            unk   <= (base == ZERO);
            state <= FIX;
          end else begin
            acc   <= ONE;
            sq    <= b_mag;
            e     <= expo;
            neg   <= b_neg & expo[0];
            unk   <= 1'b0;
            state <= (expo == '0) ? FIX : LOOP;
          end
        end
        LOOP: begin
          if (e[0]) acc <= acc * sq;
          sq <= sq * sq;
          e  <= e >> 1;
          if ((e >> 1) == '0) state <= FIX;
        end
        FIX: begin
          result         <= neg ? -acc : acc;
          result_unknown <= unk;
          done           <= 1'b1;
          state          <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(result));
  // R6
  unknown_zero_chk: assert property (@(posedge clk) disable iff (rst) result_unknown |-> (result == ZERO));
endmodule

// File: tb/int_pow_seq_bench.sv
module int_pow_seq_bench;
  localparam int W  = 8;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  base = '0;
  logic          base_signed = 1'b0;
  logic [EW-1:0] expo = '0;
  logic          exp_signed = 1'b0;
  logic          busy, done, result_unknown;
  logic [W-1:0]  result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  int_pow_seq #(.WIDTH(W), .EXP_W(EW)) u_int_pow_seq (
    .clk(clk), .rst(rst), .start(start), .base(base), .base_signed(base_signed),
    .expo(expo), .exp_signed(exp_signed), .busy(busy), .done(done),
    .result(result), .result_unknown(result_unknown));

  // {base, base_signed, expo, exp_signed, expected, unknown}
  localparam logic [22:0] VEC [13] = '{
    {8'h03, 1'b0, 4'h5, 1'b0, 8'hF3, 1'b0},  // R2
    {8'h03, 1'b0, 4'h6, 1'b0, 8'hD9, 1'b0},  // R2 wrap
    {8'hFD, 1'b1, 4'h3, 1'b0, 8'hE5, 1'b0},  // R3 odd
    {8'hFD, 1'b1, 4'h4, 1'b0, 8'h51, 1'b0},  // R3 even
    {8'h02, 1'b0, 4'h9, 1'b0, 8'h00, 1'b0},  // R7 past width
    {8'h02, 1'b0, 4'h7, 1'b0, 8'h80, 1'b0},  // R7
    {8'h80, 1'b1, 4'h1, 1'b0, 8'h80, 1'b0},  // R3 most negative
    {8'h00, 1'b1, 4'hF, 1'b1, 8'h00, 1'b1},  // R6
    {8'hFF, 1'b1, 4'hD, 1'b1, 8'hFF, 1'b0},  // R5
    {8'hFF, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0},  // R4 unsigned all ones
    {8'h00, 1'b0, 4'h0, 1'b0, 8'h01, 1'b0},  // R1
    {8'h05, 1'b0, 4'hF, 1'b0, 8'h8D, 1'b0},  // R2 full loop
    {8'hFF, 1'b1, 4'hF, 1'b0, 8'hFF, 1'b0}   // R3 unsigned odd exponent
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_pow(int b, int e, output logic unk);
    longint y = 1;
    unk = 1'b0;
    if (e < 0) begin
      if (b == 0) begin unk = 1'b1; return 8'h00; end
      if (b == 1) return 8'h01;
      if (b == -1) return (e % 2 == 0) ? 8'h01 : 8'hFF;
      return 8'h00;
    end
    for (int k = 0; k < e; k++) y = (y * b) & 255;
    return y[7:0];
  endfunction

  task automatic run(input logic [W-1:0] b, input logic bs, input logic [EW-1:0] e,
                     input logic es, output int lat);
    @(negedge clk);
    base = b; base_signed = bs; expo = e; exp_signed = es; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", 32'(busy), 32'd1);
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check("R8 latency bound", 32'(lat <= EW + 2), 32'd1);
  endtask

  task automatic expect_pow(string tag, logic [W-1:0] b, logic bs, logic [EW-1:0] e,
                            logic es, logic [W-1:0] exp_r, logic exp_u);
    int lat;
    run(b, bs, e, es, lat);
    check(tag, 32'(result), 32'(exp_r));
    check({tag, " unknown flag"}, 32'(result_unknown), 32'(exp_u));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic u;
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R10
    check("R10 reset busy", 32'(busy), 32'd0);
    check("R10 reset done", 32'(done), 32'd0);
    check("R10 reset result", 32'(result), 32'd0);
    check("R10 reset unknown", 32'(result_unknown), 32'd0);
    rst = 1'b0;

    foreach (VEC[i])
      expect_pow("R1-R7 table", VEC[i][22:15], VEC[i][14], VEC[i][13:10], VEC[i][9],
                 VEC[i][8:1], VEC[i][0]);

    for (int i = -4; i <= 3; i++)
      for (int j = -4; j <= 3; j++) begin
        r = ref_pow(i, j, u);
        expect_pow("R3 R4 R5 signed sweep", 8'(i), 1'b1, 4'(j), 1'b1, r, u);
      end
    for (int i = 0; i <= 7; i++)
      for (int j = 0; j <= 7; j++) begin
        r = ref_pow(i, j, u);
        expect_pow("R2 unsigned sweep", 8'(i), 1'b0, 4'(j), 1'b0, r, u);
      end
    for (int j = 0; j < 16; j++)
      expect_pow("R7 shift equivalence", 8'd2, 1'b0, 4'(j), 1'b0, 8'(9'd1 << j), 1'b0);
    expect_pow("R1 zero exponent signed", 8'hFB, 1'b1, 4'h0, 1'b1, 8'h01, 1'b0);
    expect_pow("R4 base one negative exp", 8'h01, 1'b1, 4'hC, 1'b1, 8'h01, 1'b0);
    expect_pow("R5 even negative exp", 8'hFF, 1'b1, 4'hE, 1'b1, 8'h01, 1'b0);

    // R8 done is a single pulse; R9 result held afterwards
    @(negedge clk);
    check("R8 done one cycle", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    check("R9 result held", 32'(result), 32'h01);

    // R9 start while busy is ignored
    @(negedge clk);
    base = 8'd3; base_signed = 1'b0; expo = 4'd5; exp_signed = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    base = 8'd2; expo = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check("R9 start while busy ignored", 32'(result), 32'hF3);
    @(negedge clk);
    check("R9 no second run", 32'(busy), 32'd0);

    // R10 reset mid-run
    run(8'd3, 1'b0, 4'd5, 1'b0, lat);
    @(negedge clk);
    base = 8'd5; expo = 4'hF; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset clears busy", 32'(busy), 32'd0);
    check("R10 reset clears result", 32'(result), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule